// File: doc/BRIEF.md
# Twin-Mask Vector Element Stepper

This block runs the element loop of a vector operation whose source and destination operands each carry their own predicate mask. On a start pulse it captures a vector length, two starting step positions, two scalar flags and the selectors for two masks. It then emits one element pair per accepted handshake. Each pair holds a source index and a destination index. The source position moves past clear source-mask bits and the destination position moves past clear destination-mask bits, each on its own. One loop can therefore compress, expand or do both at once.

Each mask is built when the loop starts, by its own selector. The choices are all ones, a register value, the inverse of a register value, a one-hot bit taken from a register value, or one chosen bit from a run of consecutive 4-bit condition fields, optionally inverted. The block emits no separate write-enable: an accepted pair on the issue port is the element write. Once the loop ends, the two step outputs hold the positions from which an interrupted loop can be restarted.

Top module: `vec_pair_stepper`

## Requirements
- R1: When a start arrives with a vector length of zero, done_o pulses in the next cycle, no pair is issued, and the step outputs equal the start step inputs.
- R2: Each issued pair joins the lowest set source-mask bit at or after the source step with the lowest set destination-mask bit at or after the destination step. Only positions below the vector length count. The loop ends when either side has no such bit.
- R3: With source mask 0b101, an all-ones destination mask and length 3, the pairs are (0,0) and (2,1), and destination 2 is never issued.
- R4: With an all-ones source mask, destination mask 0b101 and length 3, the pairs are (0,0) and (1,2).
- R5: Scanning starts at the given start steps. With steps 1 and 2, source mask 0b0101, destination mask equal to the inverse of 0b0101, and length 4, the only pair is (2,3).
- R6: The mask selector encodings are: 0 all ones, 1 register value, 2 bitwise inverse of the register, 3 one-hot (bit k set when the register equals k, no bit set when the register is 64 or more). Codes 6 and 7 act as all ones. With a register value of 1, mode 3 gives 0b010.
- R7: In selector codes 4 (true) and 5 (inverted), mask bit i is bit k of condition field (base+i) mod NCR. Condition field f occupies cr_i[4f+3:4f], and k is the 2-bit bit-select (0 lt, 1 gt, 2 eq, 3 so). Source and destination may select different bits from the same base.
- R8: With the destination scalar flag set, at most one pair is issued, and its destination index is the destination start step. With the source scalar flag set, every pair carries the source start step, and the source mask is not consulted.
- R9: A mask that has no set bit below the length issues nothing and ends with done_o. An operation started afterwards behaves as if that one had never run.
- R10: While iss_valid_o is high and iss_ready_i is low, the pair is held unchanged. With iss_ready_i held high, a loop of n pairs issues one pair per cycle, and done_o follows one cycle after the last pair.
- R11: At done_o, src_step_o and dst_step_o give one past the last issued non-scalar index on each side. A side with no issued pair, or a scalar side, keeps its start step.
- R12: done_o lasts one cycle and is never high together with iss_valid_o. A start pulse that arrives while a loop is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| vl_i | input | VLW | Vector length, 0..MAXVL |
| src_step_i | input | VLW | Source start step |
| dst_step_i | input | VLW | Destination start step |
| src_mode_i | input | 3 | Source mask selector |
| src_sel_i | input | 2 | Source condition bit select |
| src_reg_i | input | REG_W | Source mask register value |
| dst_mode_i | input | 3 | Destination mask selector |
| dst_sel_i | input | 2 | Destination condition bit select |
| dst_reg_i | input | REG_W | Destination mask register value |
| cr_i | input | 4*NCR | Condition fields, 4 bits each |
| cr_base_i | input | CBW | First condition field used |
| src_scalar_i | input | 1 | Source operand is scalar |
| dst_scalar_i | input | 1 | Destination operand is scalar |
| iss_ready_i | input | 1 | Consumer accepts the current pair |
| iss_valid_o | output | 1 | A pair is presented |
| iss_src_o | output | VLW | Source element index |
| iss_dst_o | output | VLW | Destination element index |
| done_o | output | 1 | Loop complete, one-cycle pulse |
| src_step_o | output | VLW | Source resume position |
| dst_step_o | output | VLW | Destination resume position |

## Verification
The stage that loads a new pair also ends the loop, so in one cycle the final pair can be accepted and the end of the loop recognised. The last handshake and done_o therefore meet at the same clock edge. The bench provokes this with ready held high, where the last pair is consumed at the very edge that decides termination, and with random ready, where the last pair is stalled. It checks that done_o appears only after iss_valid_o has dropped and never beside it. It also checks that the pair count and the resume steps match the model, and that with ready held high the run lasts exactly one cycle more than the number of pairs.

// File: rtl/vps_pkg.sv
package vps_pkg;
  typedef enum logic [2:0] {
    MM_ALL    = 3'd0,
    MM_REG    = 3'd1,
    MM_INV    = 3'd2,
    MM_ONEHOT = 3'd3,
    MM_CR     = 3'd4,
    MM_CRN    = 3'd5
  } mask_mode_e;
endpackage

// File: rtl/vps_mask_gen.sv
module vps_mask_gen #(
  parameter int MAXVL = 64,
  parameter int REG_W = 64,
  parameter int NCR   = 64,
  localparam int CBW  = $clog2(NCR)
) (
  input  logic [2:0]         mode_i,
  input  logic [1:0]         sel_i,
  input  logic [REG_W-1:0]   reg_i,
  input  logic [4*NCR-1:0]   cr_i,
  input  logic [CBW-1:0]     base_i,
  output logic [MAXVL-1:0]   mask_o
);
  import vps_pkg::*;

  logic [MAXVL-1:0] regx;
  logic [MAXVL-1:0] onehot;
  logic [MAXVL-1:0] crbits;

  // Register value fitted to the mask width
  generate
    if (REG_W >= MAXVL) begin : g_trunc
      assign regx = reg_i[MAXVL-1:0];
    end else begin : g_ext
      assign regx = {{(MAXVL-REG_W){1'b0}}, reg_i};
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < MAXVL; i++) begin
      onehot[i] = (reg_i == REG_W'(i));
    end
  end

  // Element i reads condition field base+i (wrapping)
  always_comb begin
    for (int i = 0; i < MAXVL; i++) begin
      logic [CBW-1:0] fld;
      fld = base_i + CBW'(i);
      crbits[i] = cr_i[{fld, sel_i}];
    end
  end

  always_comb begin
    case (mask_mode_e'(mode_i))
      MM_REG:    mask_o = regx;
      MM_INV:    mask_o = ~regx;
      MM_ONEHOT: mask_o = onehot;
      MM_CR:     mask_o = crbits;
      MM_CRN:    mask_o = ~crbits;
      default:   mask_o = '1;
    endcase
  end

  always_comb begin
    if (mode_i == 3'd3) begin
      assert_onehot_R6: assert ($onehot0(mask_o));
    end
  end
endmodule

// File: rtl/vps_step_scan.sv
module vps_step_scan #(
  parameter int MAXVL = 64,
  localparam int VLW  = $clog2(MAXVL+1)
) (
  input  logic [MAXVL-1:0] mask_i,
  input  logic [VLW-1:0]   pos_i,
  input  logic [VLW-1:0]   vl_i,
  input  logic             scalar_i,
  output logic [VLW-1:0]   idx_o,
  output logic             found_o
);
  logic [MAXVL-1:0] cand;
  logic [VLW-1:0]   low;

  always_comb begin
    for (int i = 0; i < MAXVL; i++) begin
      cand[i] = mask_i[i] && (VLW'(i) >= pos_i) && (VLW'(i) < vl_i);
    end
  end

  // Lowest set candidate wins
  always_comb begin
    low = '0;
    for (int i = MAXVL-1; i >= 0; i--) begin
      if (cand[i]) low = VLW'(i);
    end
  end

  assign idx_o   = scalar_i ? pos_i : low;
  assign found_o = scalar_i | (|cand);

  always_comb begin
    if (found_o && !scalar_i) begin
      assert_hit_set_R2: assert ((|(mask_i & (MAXVL'(1) << idx_o))) && idx_o >= pos_i && idx_o < vl_i);
    end
  end
endmodule

// File: rtl/vec_pair_stepper.sv
module vec_pair_stepper #(
  parameter int MAXVL = 64,
  parameter int REG_W = 64,
  parameter int NCR   = 64,
  localparam int VLW  = $clog2(MAXVL+1),
  localparam int CBW  = $clog2(NCR)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [VLW-1:0]     vl_i,
  input  logic [VLW-1:0]     src_step_i,
  input  logic [VLW-1:0]     dst_step_i,
  input  logic [2:0]         src_mode_i,
  input  logic [1:0]         src_sel_i,
  input  logic [REG_W-1:0]   src_reg_i,
  input  logic [2:0]         dst_mode_i,
  input  logic [1:0]         dst_sel_i,
  input  logic [REG_W-1:0]   dst_reg_i,
  input  logic [4*NCR-1:0]   cr_i,
  input  logic [CBW-1:0]     cr_base_i,
  input  logic               src_scalar_i,
  input  logic               dst_scalar_i,
  input  logic               iss_ready_i,
  output logic               iss_valid_o,
  output logic [VLW-1:0]     iss_src_o,
  output logic [VLW-1:0]     iss_dst_o,
  output logic               done_o,
  output logic [VLW-1:0]     src_step_o,
  output logic [VLW-1:0]     dst_step_o
);
  logic [MAXVL-1:0] smask_d, dmask_d, smask_q, dmask_q;
  logic [VLW-1:0]   vl_q, spos_q, dpos_q, isrc_q, idst_q;
  logic [VLW-1:0]   ns, nd;
  logic             sfound, dfound;
  logic             ssc_q, dsc_q, stop_q, busy_q, vld_q, done_q;
  logic             load;

  vps_mask_gen #(.MAXVL(MAXVL), .REG_W(REG_W), .NCR(NCR)) u_smask (
    .mode_i(src_mode_i), .sel_i(src_sel_i), .reg_i(src_reg_i),
    .cr_i(cr_i), .base_i(cr_base_i), .mask_o(smask_d)
  );

  vps_mask_gen #(.MAXVL(MAXVL), .REG_W(REG_W), .NCR(NCR)) u_dmask (
    .mode_i(dst_mode_i), .sel_i(dst_sel_i), .reg_i(dst_reg_i),
    .cr_i(cr_i), .base_i(cr_base_i), .mask_o(dmask_d)
  );

  vps_step_scan #(.MAXVL(MAXVL)) u_sscan (
    .mask_i(smask_q), .pos_i(spos_q), .vl_i(vl_q), .scalar_i(ssc_q),
    .idx_o(ns), .found_o(sfound)
  );

  vps_step_scan #(.MAXVL(MAXVL)) u_dscan (
    .mask_i(dmask_q), .pos_i(dpos_q), .vl_i(vl_q), .scalar_i(dsc_q),
    .idx_o(nd), .found_o(dfound)
  );

  assign load = busy_q && (!vld_q || iss_ready_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      vld_q   <= 1'b0;
      done_q  <= 1'b0;
      stop_q  <= 1'b0;
      ssc_q   <= 1'b0;
      dsc_q   <= 1'b0;
      vl_q    <= '0;
      spos_q  <= '0;
      dpos_q  <= '0;
      isrc_q  <= '0;
      idst_q  <= '0;
      smask_q <= '0;
      dmask_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          vl_q    <= vl_i;
          spos_q  <= src_step_i;
          dpos_q  <= dst_step_i;
          smask_q <= smask_d;
          dmask_q <= dmask_d;
          ssc_q   <= src_scalar_i;
          dsc_q   <= dst_scalar_i;
          stop_q  <= 1'b0;
          if (vl_i == '0) done_q <= 1'b1;
          else            busy_q <= 1'b1;
        end
      end else if (load) begin
        if (sfound && dfound && !stop_q) begin
          vld_q  <= 1'b1;
          isrc_q <= ns;
          idst_q <= nd;
          if (!ssc_q) spos_q <= ns + VLW'(1);
          if (!dsc_q) dpos_q <= nd + VLW'(1);
          if (dsc_q)  stop_q <= 1'b1;
        end else begin
          vld_q  <= 1'b0;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign iss_valid_o = vld_q;
  assign iss_src_o   = isrc_q;
  assign iss_dst_o   = idst_q;
  assign done_o      = done_q;
  assign src_step_o  = spos_q;
  assign dst_step_o  = dpos_q;

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !iss_ready_i) |=> (vld_q && $stable(isrc_q) && $stable(idst_q)));

  assert_done_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(done_q && vld_q));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  assert_zero_vl_R1: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_q && vl_i == '0) |=> (done_q && !vld_q));

  assert_src_legal_R2: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !ssc_q) |-> (isrc_q < vl_q && (|(smask_q & (MAXVL'(1) << isrc_q)))));

  assert_dst_legal_R2: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !dsc_q) |-> (idst_q < vl_q && (|(dmask_q & (MAXVL'(1) << idst_q)))));

  assert_scalar_dst_R8: assert property (@(posedge clk) disable iff (rst)
    (vld_q && iss_ready_i && dsc_q) |=> !vld_q);
endmodule

// File: tb/vec_pair_stepper_tb.sv
module vec_pair_stepper_tb;
  localparam int VLW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [VLW-1:0] vl_i = '0, src_step_i = '0, dst_step_i = '0;
  logic [2:0] src_mode_i = '0, dst_mode_i = '0;
  logic [1:0] src_sel_i = '0, dst_sel_i = '0;
  logic [63:0] src_reg_i = '0, dst_reg_i = '0;
  logic [255:0] cr_i = '0;
  logic [5:0] cr_base_i = '0;
  logic src_scalar_i = 1'b0, dst_scalar_i = 1'b0;
  logic iss_ready_i = 1'b0;
  logic iss_valid_o, done_o;
  logic [VLW-1:0] iss_src_o, iss_dst_o, src_step_o, dst_step_o;

  int errors = 0;
  int checks = 0;
  longint cyc = 0;

  vec_pair_stepper u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .vl_i(vl_i),
    .src_step_i(src_step_i), .dst_step_i(dst_step_i),
    .src_mode_i(src_mode_i), .src_sel_i(src_sel_i), .src_reg_i(src_reg_i),
    .dst_mode_i(dst_mode_i), .dst_sel_i(dst_sel_i), .dst_reg_i(dst_reg_i),
    .cr_i(cr_i), .cr_base_i(cr_base_i),
    .src_scalar_i(src_scalar_i), .dst_scalar_i(dst_scalar_i),
    .iss_ready_i(iss_ready_i), .iss_valid_o(iss_valid_o),
    .iss_src_o(iss_src_o), .iss_dst_o(iss_dst_o), .done_o(done_o),
    .src_step_o(src_step_o), .dst_step_o(dst_step_o)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] bmask(input logic [2:0] mode, input logic [1:0] sel,
                                        input logic [63:0] rv);
    logic [63:0] m;
    case (mode)
      3'd1: m = rv;
      3'd2: m = ~rv;
      3'd3: m = (rv < 64) ? (64'd1 << rv) : 64'd0;
      3'd4, 3'd5: begin
        for (int i = 0; i < 64; i++)
          m[i] = cr_i[4*((int'(cr_base_i) + i) % 64) + int'(sel)] ^ (mode == 3'd5);
      end
      default: m = '1;
    endcase
    return m;
  endfunction

  int exp_n;
  int exp_s [0:69];
  int exp_d [0:69];
  int exp_fs, exp_fd;

  task automatic model();
    logic [63:0] sm, dm;
    int s, d, ns, nd, vl;
    bit fs, fd, stop;
    sm = bmask(src_mode_i, src_sel_i, src_reg_i);
    dm = bmask(dst_mode_i, dst_sel_i, dst_reg_i);
    vl = int'(vl_i);
    s = int'(src_step_i); d = int'(dst_step_i);
    exp_n = 0; stop = 0;
    if (vl != 0) begin
      for (int k = 0; k < 70; k++) begin
        fs = src_scalar_i; ns = s;
        if (!src_scalar_i)
          for (int i = 63; i >= 0; i--) if (i >= s && i < vl && sm[i]) begin fs = 1; ns = i; end
        fd = dst_scalar_i; nd = d;
        if (!dst_scalar_i)
          for (int i = 63; i >= 0; i--) if (i >= d && i < vl && dm[i]) begin fd = 1; nd = i; end
        if (!(fs && fd) || stop) break;
        exp_s[exp_n] = ns; exp_d[exp_n] = nd; exp_n++;
        if (!src_scalar_i) s = ns + 1;
        if (!dst_scalar_i) d = nd + 1; else stop = 1;
      end
    end
    exp_fs = s; exp_fd = d;
  endtask

  // Runs one loop; poke issues a second start while busy
  task automatic run_op(input string tag, input bit always_rdy, input bit poke);
    int got, iter;
    bit stall, fin, rdy;
    logic [VLW-1:0] hs, hd;
    model();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    got = 0; iter = 0; stall = 0; fin = 0;
    while (!fin) begin
      if (poke && iter == 2) begin start_i = 1'b1; vl_i = '0; src_mode_i = 3'd2; end
      if (poke && iter == 3) start_i = 1'b0;
      if (done_o) begin
        fin = 1;
        check(!iss_valid_o, "R12", "valid beside done", iss_valid_o, 0);
      end else begin
        if (stall)
          check(iss_valid_o && iss_src_o == hs && iss_dst_o == hd, "R10", "stalled pair",
                {iss_src_o, iss_dst_o}, {hs, hd});
        rdy = always_rdy ? 1'b1 : ($urandom % 4 != 0);
        iss_ready_i = rdy;
        stall = 0;
        if (iss_valid_o) begin
          if (rdy) begin
            if (got < exp_n)
              check(int'(iss_src_o) == exp_s[got] && int'(iss_dst_o) == exp_d[got], tag,
                    "pair", {iss_src_o, iss_dst_o}, {exp_s[got][6:0], exp_d[got][6:0]});
            else
              check(0, tag, "extra pair", got, exp_n);
            got++;
          end else begin
            stall = 1; hs = iss_src_o; hd = iss_dst_o;
          end
        end
        @(negedge clk);
        iter++;
        if (iter > 3000) begin check(0, tag, "loop never ended", iter, 0); fin = 1; end
      end
    end
    check(got == exp_n, tag, "pair count", got, exp_n);
    check(int'(src_step_o) == exp_fs && int'(dst_step_o) == exp_fd, "R11", "resume steps",
          {src_step_o, dst_step_o}, {exp_fs[6:0], exp_fd[6:0]});
    if (always_rdy)
      check(iter == ((vl_i == 0) ? 0 : exp_n + 1), "R10", "cycles to done", iter,
            (vl_i == 0) ? 0 : exp_n + 1);
    @(negedge clk);
    check(!done_o, "R12", "done pulse width", done_o, 0);
    iss_ready_i = 1'b0;
  endtask

  task automatic setup(input int vl, input int s0, input int d0,
                       input logic [2:0] sm, input logic [63:0] sr,
                       input logic [2:0] dm, input logic [63:0] dr);
    vl_i = VLW'(vl); src_step_i = VLW'(s0); dst_step_i = VLW'(d0);
    src_mode_i = sm; src_reg_i = sr; dst_mode_i = dm; dst_reg_i = dr;
    src_scalar_i = 0; dst_scalar_i = 0; src_sel_i = 0; dst_sel_i = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!iss_valid_o && !done_o && src_step_o == 0 && dst_step_o == 0, "R12", "reset state",
          {iss_valid_o, done_o}, 0);

    // R1: zero length
    setup(0, 3, 5, 3'd0, 0, 3'd0, 0);
    run_op("R1", 1, 0);

    // R3: compress
    setup(3, 0, 0, 3'd1, 64'b101, 3'd0, 0);
    run_op("R3", 1, 0);
    check(exp_n == 2 && exp_d[1] == 1, "R3", "model pairs", exp_n, 2);

    // R4: expand
    setup(3, 0, 0, 3'd0, 0, 3'd1, 64'b101);
    run_op("R4", 1, 0);

    // R2: twin, source 0b101, dest 0b010 via inverse of 0b101
    setup(3, 0, 0, 3'd1, 64'b101, 3'd2, 64'b101);
    run_op("R2", 0, 0);

    // R5: resume from steps 1 and 2
    setup(4, 1, 2, 3'd1, 64'b0101, 3'd2, 64'b0101);
    run_op("R5", 1, 0);
    check(exp_n == 1 && exp_s[0] == 2 && exp_d[0] == 3, "R5", "model pair", exp_n, 1);

    // R6: one-hot destination from register value 1
    setup(3, 0, 0, 3'd1, 64'b100, 3'd3, 64'd1);
    run_op("R6", 1, 0);
    setup(3, 0, 0, 3'd0, 0, 3'd3, 64'd200);
    run_op("R6", 1, 0);

    // R7: condition fields, eq for source and lt for destination, base 4
    setup(4, 1, 2, 3'd4, 0, 3'd4, 0);
    cr_i = '0;
    cr_i[4*4+2] = 1; cr_i[4*6+2] = 1; cr_i[4*5+0] = 1; cr_i[4*7+0] = 1;
    cr_base_i = 6'd4; src_sel_i = 2'd2; dst_sel_i = 2'd0;
    run_op("R7", 1, 0);
    // R7: inverted condition bit
    setup(2, 0, 0, 3'd0, 0, 3'd5, 0);
    cr_base_i = 6'd4; dst_sel_i = 2'd2;
    run_op("R7", 0, 0);

    // R8: scalar destination, then scalar source
    setup(3, 0, 2, 3'd0, 0, 3'd0, 0); dst_scalar_i = 1;
    run_op("R8", 1, 0);
    setup(3, 5, 0, 3'd1, 0, 3'd0, 0); src_scalar_i = 1;
    run_op("R8", 0, 0);

    // R9: all-zero mask, then unmasked op
    setup(3, 0, 0, 3'd1, 64'd0, 3'd0, 0);
    run_op("R9", 1, 0);
    setup(3, 0, 0, 3'd0, 0, 3'd0, 0);
    run_op("R9", 1, 0);

    // R12: start ignored while busy
    setup(8, 0, 0, 3'd0, 0, 3'd1, 64'hFF);
    run_op("R12", 0, 1);

    // R2: constrained random
    for (int t = 0; t < 300; t++) begin
      setup(($urandom % 5 == 0) ? 64 : int'($urandom % 20), int'($urandom % 6), int'($urandom % 6),
            3'($urandom % 8), {$urandom, $urandom}, 3'($urandom % 8), {$urandom, $urandom});
      if ($urandom % 4 == 0) begin src_reg_i = 64'($urandom % 12); end
      if ($urandom % 4 == 0) begin dst_reg_i = 64'($urandom % 12); end
      src_sel_i = 2'($urandom); dst_sel_i = 2'($urandom);
      cr_base_i = 6'($urandom);
      for (int w = 0; w < 8; w++) cr_i[32*w +: 32] = $urandom;
      src_scalar_i = ($urandom % 8 == 0);
      dst_scalar_i = ($urandom % 8 == 0);
      run_op("R2", ($urandom % 3 == 0), 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule